// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a single-client request port inside the chip to an external asynchronous static RAM. The RAM is 16 bits wide and 256K words deep. The client presents a request strobe, a direction flag, an 18-bit word address and 16 bits of write data. The controller then runs one fixed, timed access on the memory pins. It drives the address, the active-low chip, output, write and byte enables, and a shared bidirectional data bus.

Every access takes the same number of clock cycles. With a 5 ns clock, the default length of 12 cycles, including the idle cycle in which the next request is taken, gives a 60 ns back-to-back access period. A `ready` output tells the client when a request will be taken. Read data comes back on two ports. One is a copy captured in a register at the end of the access and held until the next read. The other is a direct, unregistered path from the data bus.

All memory control pins come straight from flip-flops, so they do not glitch. The write strobe falls one cycle after the access starts and rises one cycle before the bus is released. This gives address setup time and data hold time around the write pulse.

Top module: `async_sram_port`

## Requirements
- R1: After reset the controller is idle: `ready` is 1 and `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are all 1.
- R2: A request (`req`=1) is accepted at a rising edge where `ready` is 1. `ready` is then 0 for ACCESS_CYCLES-1 = 11 cycles and is 1 again in the 12th cycle. Requests presented continuously are accepted exactly 12 cycles apart.
- R3: A request presented while `ready` is 0 is ignored. The running access keeps its address, data and length, and the ignored request never reaches the memory.
- R4: For the whole access, `mem_addr` holds the address sampled at acceptance.
- R5: `rw`=1 selects a read and `rw`=0 selects a write. During a read, `mem_ce_n` and `mem_oe_n` are 0 and `mem_we_n` is 1 for all busy cycles.
- R6: `rd_data_raw` follows the data bus with no register. `rd_data_reg` captures the bus in the last busy cycle of a read, so it is valid when `ready` returns. It is held through later writes.
- R7: During a write, the controller drives the bus with the accepted data for all 11 busy cycles, and `mem_oe_n` stays 1. Counting busy cycles from 1, `mem_we_n` is 0 in cycles 2 to 10 and is 1 in cycles 1 and 11, so the strobe rises one cycle before the bus is released.
- R8: Both byte enables are 0 in every busy cycle of any access and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (5 ns nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 18 | Word address |
| wr_data | input | 16 | Data to write |
| ready | output | 1 | Idle, a request will be accepted |
| rd_data_reg | output | 16 | Read data captured at end of read |
| rd_data_raw | output | 16 | Read data taken directly off the bus |
| mem_addr | output | 18 | SRAM address |
| mem_ce_n | output | 1 | SRAM chip enable, active low |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_n | output | 1 | SRAM write enable, active low |
| mem_lb_n | output | 1 | SRAM lower byte enable, active low |
| mem_ub_n | output | 1 | SRAM upper byte enable, active low |
| mem_dq | inout | 16 | SRAM data bus |

## Verification
The bench counts falling edges from the rising edge that accepts a request.

- Pin levels are due from the first falling edge after acceptance, because they come from registers loaded on that edge.
- `ready` must be 0 at falling edges 1 to 11 and 1 at edge 12. At edge 12 the registered read data is compared.
- The write strobe is checked at edges 1, 2, 10 and 11.
- The unregistered read data is compared mid-access at edge 6.
- A request injected at edge 4 of a write must leave the address at edge 6, the access length and the stored memory contents unchanged.
- Back-to-back spacing is measured as the time between accepting edges.

// File: rtl/async_sram_port_pkg.sv
// Shared types for the asynchronous SRAM access controller.
package async_sram_port_pkg;
    // Direction flag as seen on the rw input (1 = read, 0 = write).
    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } sram_op_e;
endpackage

// File: rtl/asp_sequencer.sv
// Access sequencer: accepts a request while idle and counts through a fixed
// access of ACCESS_CYCLES-1 busy cycles; the idle cycle completes the period.
// Assumes requests are synchronous to clk. Exports next-state values so the
// pin stage can register its outputs in step with the state.
module asp_sequencer
    import async_sram_port_pkg::*;
#(
    parameter int ACCESS_CYCLES = 12,
    localparam int CW = $clog2(ACCESS_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          rw,
    output logic          ready,
    output logic          accept,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output sram_op_e      op,
    output logic          last,
    output logic          nxt_busy,
    output logic [CW-1:0] nxt_cnt,
    output sram_op_e      nxt_op
);
    localparam logic [CW-1:0] LAST_IDX = CW'(ACCESS_CYCLES - 2);

    assign ready  = !busy;
    assign accept = req && !busy;
    assign last   = busy && (cnt == LAST_IDX);

    // Next-state decode for the busy flag, cycle index and operation.
    always_comb begin
        nxt_busy = busy;
        nxt_cnt  = cnt;
        nxt_op   = op;
        if (accept) begin
            nxt_busy = 1'b1;
            nxt_cnt  = '0;
            nxt_op   = sram_op_e'(rw);
        end else if (busy) begin
            if (cnt == LAST_IDX) begin
                nxt_busy = 1'b0;
                nxt_cnt  = '0;
            end else begin
                nxt_cnt = cnt + 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            op   <= OP_WRITE;
        end else begin
            busy <= nxt_busy;
            cnt  <= nxt_cnt;
            op   <= nxt_op;
        end
    end

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    // R3
    busy_runs_to_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && $stable(op)));
endmodule

// File: rtl/asp_cmd_latch.sv
// Command latch: holds the address and write data of the accepted request for
// the whole access. Assumes accept is only asserted while idle.
module asp_cmd_latch #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    // Capture the request fields on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr;
            wdata_q <= wr_data;
        end
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q)));
endmodule

// File: rtl/asp_pin_drive.sv
// Pin stage: registers the SRAM control strobes and the bus-drive enable from
// the sequencer's next state, so every pin comes glitch-free from a flop.
// Write strobe spans busy cycles WE_FIRST..WE_LAST (0-based), ending one
// cycle before the bus is released. Assumes ACCESS_CYCLES >= 4.
module asp_pin_drive
    import async_sram_port_pkg::*;
#(
    parameter int ACCESS_CYCLES = 12,
    localparam int CW = $clog2(ACCESS_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nxt_busy,
    input  logic [CW-1:0] nxt_cnt,
    input  sram_op_e      nxt_op,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          lb_n,
    output logic          ub_n,
    output logic          drive_en
);
    localparam logic [CW-1:0] WE_FIRST = CW'(1);
    localparam logic [CW-1:0] WE_LAST  = CW'(ACCESS_CYCLES - 3);

    logic nxt_wr, nxt_rd, nxt_we;

    // Decode the strobes for the coming cycle.
    always_comb begin
        nxt_wr = nxt_busy && (nxt_op == OP_WRITE);
        nxt_rd = nxt_busy && (nxt_op == OP_READ);
        nxt_we = nxt_wr && (nxt_cnt >= WE_FIRST) && (nxt_cnt <= WE_LAST);
    end

    // Pin registers, all strobes inactive (high) in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
            lb_n     <= 1'b1;
            ub_n     <= 1'b1;
            drive_en <= 1'b0;
        end else begin
            ce_n     <= !nxt_busy;
            oe_n     <= !nxt_rd;
            we_n     <= !nxt_we;
            lb_n     <= !nxt_busy;
            ub_n     <= !nxt_busy;
            drive_en <= nxt_wr;
        end
    end

    // R7
    we_inside_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (drive_en && !ce_n && oe_n));

    // R7
    we_release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> drive_en);

    // R5
    oe_no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!drive_en && !ce_n && we_n));

    // R8
    byte_enable_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_n == ce_n) && (ub_n == ce_n));
endmodule

// File: rtl/asp_read_capture.sv
// Read capture: registers the data bus in the last busy cycle of a read and
// holds it until the next read completes. Assumes the SRAM drives the bus
// while output enable is low.
module asp_read_capture
    import async_sram_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last,
    input  sram_op_e          op,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata_q
);
    logic take;
    assign take = last && (op == OP_READ);

    // Load the read register at the closing edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (take) rdata_q <= dq_in;
    end

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rdata_q));
endmodule

// File: rtl/async_sram_port.sv
// Top: asynchronous SRAM access controller for a single client. Connects
// sequencer, command latch, pin stage and read capture, and owns the
// tristate data bus. Assumes one synchronous clock for client and controller.
module async_sram_port
    import async_sram_port_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int ACCESS_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data_reg,
    output logic [DATA_W-1:0] rd_data_raw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int CW = $clog2(ACCESS_CYCLES);

    logic          accept, busy, last, nxt_busy, drive_en;
    logic [CW-1:0] cnt, nxt_cnt;
    sram_op_e      op, nxt_op;
    logic [DATA_W-1:0] wdata_q;

    asp_sequencer #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .ready(ready),
        .accept(accept), .busy(busy), .cnt(cnt), .op(op), .last(last),
        .nxt_busy(nxt_busy), .nxt_cnt(nxt_cnt), .nxt_op(nxt_op)
    );

    asp_cmd_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
        .addr(addr), .wr_data(wr_data), .addr_q(mem_addr), .wdata_q(wdata_q)
    );

    asp_pin_drive #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_pins (
        .clk(clk), .rst_n(rst_n), .nxt_busy(nxt_busy), .nxt_cnt(nxt_cnt),
        .nxt_op(nxt_op), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .lb_n(mem_lb_n), .ub_n(mem_ub_n), .drive_en(drive_en)
    );

    asp_read_capture #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .last(last), .op(op),
        .dq_in(mem_dq), .rdata_q(rd_data_reg)
    );

    // Tristate bus: driven only by writes, unregistered read path straight off it.
    assign mem_dq      = drive_en ? wdata_q : {DATA_W{1'bz}};
    assign rd_data_raw = mem_dq;
endmodule

// File: tb/async_sram_port_bench.sv
`timescale 1ns/1ps
module async_sram_port_bench;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int N  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic ready;
    logic [DW-1:0] rd_data_reg, rd_data_raw;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    wire  [DW-1:0] mem_dq;

    always #2 clk = ~clk;

    async_sram_port u_async_sram_port (
        .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .addr(addr),
        .wr_data(wr_data), .ready(ready), .rd_data_reg(rd_data_reg),
        .rd_data_raw(rd_data_raw), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq(mem_dq)
    );

    // Behavioural asynchronous SRAM.
    logic [DW-1:0] sram [logic [AW-1:0]];
    logic [DW-1:0] sram_out;
    always_comb sram_out = sram.exists(mem_addr) ? sram[mem_addr] : 16'h0000;
    assign mem_dq = (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
                    ? sram_out : {DW{1'bz}};
    always @(posedge mem_we_n) if (mem_ce_n === 1'b0) sram[mem_addr] = mem_dq;

    // Expected contents, kept by the bench.
    logic [DW-1:0] expm [logic [AW-1:0]];
    function automatic logic [DW-1:0] exp_of(input logic [AW-1:0] a);
        return expm.exists(a) ? expm[a] : 16'h0000;
    endfunction

    int checks = 0;
    int errors = 0;
    realtime last_accept = 0.0;
    logic [DW-1:0] last_rd = '0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, expv, $time);
        end
    endtask

    // One access, called at a falling edge while ready is 1.
    task automatic access(input bit is_rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit b2b, input bit inject);
        req = 1'b1; rw = is_rd; addr = a; wr_data = d;
        @(posedge clk);
        if (b2b) chk(($realtime - last_accept) == N * 4.0, "R2 b2b period",
                     32'($rtoi($realtime - last_accept)), 32'(N * 4));
        last_accept = $realtime;
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= N - 1; k++) begin
            chk(ready == 1'b0, "R2 ready low", ready, 0);
            chk(mem_ce_n == 1'b0 && mem_lb_n == 1'b0 && mem_ub_n == 1'b0,
                "R8 enables low", {mem_ce_n, mem_lb_n, mem_ub_n}, 0);
            if (k == 4 && inject) begin
                req = 1'b1; rw = 1'b0; addr = a ^ 18'h00F0F; wr_data = ~d;
            end
            if (k == 5) req = 1'b0;
            if (k == 6) chk(mem_addr == a, "R4 addr held", mem_addr, a);
            if (is_rd) begin
                chk(mem_oe_n == 1'b0 && mem_we_n == 1'b1, "R5 read strobes",
                    {mem_oe_n, mem_we_n}, 2'b01);
                if (k == 6) chk(rd_data_raw == exp_of(a), "R6 raw data",
                                rd_data_raw, exp_of(a));
            end else begin
                chk(mem_oe_n == 1'b1, "R7 oe high on write", mem_oe_n, 1);
                chk(mem_dq === d, "R7 bus driven", mem_dq, d);
                if (k == 1 || k == N - 1)
                    chk(mem_we_n == 1'b1, "R7 we high at edge", mem_we_n, 1);
                if (k == 2 || k == N - 2)
                    chk(mem_we_n == 1'b0, "R7 we low inside", mem_we_n, 0);
            end
            @(negedge clk);
        end
        chk(ready == 1'b1, "R2 ready back at cycle 12", ready, 1);
        chk(mem_ce_n == 1'b1 && mem_oe_n == 1'b1 && mem_we_n == 1'b1,
            "R1 idle strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        if (is_rd) begin
            chk(rd_data_reg == exp_of(a), "R6 registered data", rd_data_reg, exp_of(a));
            last_rd = exp_of(a);
        end else begin
            expm[a] = d;
            chk(rd_data_reg == last_rd, "R6 reg held over write", rd_data_reg, last_rd);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R1 reset ready", ready, 1);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'h1F,
            "R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corner addresses, the first pair of accesses back to back.
        access(1'b0, 18'h00000, 16'hA5C3, 1'b0, 1'b0);
        access(1'b0, 18'h3FFFF, 16'h5A3C, 1'b1, 1'b0);
        access(1'b1, 18'h00000, 16'h0000, 1'b1, 1'b0);
        access(1'b1, 18'h3FFFF, 16'h0000, 1'b1, 1'b0);
        // R3: request injected mid-write must be ignored.
        access(1'b0, 18'h15555, 16'h1234, 1'b1, 1'b1);
        access(1'b1, 18'h15555 ^ 18'h00F0F, 16'h0000, 1'b1, 1'b0);
        chk(!sram.exists(18'h15555 ^ 18'h00F0F), "R3 ignored write absent", 0, 0);
        access(1'b1, 18'h15555, 16'h0000, 1'b1, 1'b0);
        // Random write/read mix.
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom);
            access(1'b0, ra, DW'($urandom), 1'b1, 1'b0);
            access(1'b1, ra, 16'h0000, 1'b1, 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule